// File: doc/BRIEF.md
# Clock Generator Configuration Write Port

This block is the serial configuration port of a clock generator. It is an I2C target that only accepts writes. It samples the bus SCL and SDA lines with the system clock and recognises start and stop conditions. It compares the 7-bit address with a fixed value, acknowledges when that address is written, and places the data bytes that follow into a small bank of configuration registers. The register outputs are parallel and drive the clock output enables and the function selection of the generator.

The block has no sub-address. Every write transfer starts loading at byte 0, and each further byte goes to the next register. There are six registers:

- byte 0 selects the function.
- bytes 1 to 5 gate groups of outputs: CPU and USB, PCI, the low and high SDRAM groups, and the reference and IOAPIC outputs.

A 1 in an enable bit turns the output on. Bits with no assigned use always read back as zero. Data written past the last register is acknowledged and then dropped.

Reads, clock stretching and arbitration are not supported. The acknowledge output is an open-drain style enable: when it is high, the pad pulls SDA low.

Top module: `cfg_i2c_slave`

## Requirements
- R1: After reset the outputs hold these values: function byte 0x00, CPU/USB enables 0x8F, PCI enables 0x7F, SDRAM low enables 0xFF, SDRAM high enables 0x0F, peripheral enables 0x11.
- R2: An address byte of 1101001 followed by a 0 (write) direction bit is acknowledged. The target holds SDA low during the ninth SCL pulse, and starts driving only while SCL is low.
- R3: An address byte with a different address, or with the direction bit set to 1, gets no acknowledge. Until the next start, the bus is ignored and no register changes.
- R4: After an acknowledged address, data bytes are taken MSB first. They are stored in order into byte 0, byte 1, and so on, and each data byte is acknowledged.
- R5: Bits with no assigned use are stored as zero. The bits kept are: byte 0 bits 1:0; byte 1 bits 7 and 3:0; byte 2 bits 6:0; byte 3 all bits; byte 4 bits 3:0; byte 5 bits 4 and 0.
- R6: The 7th data byte of a transfer and every byte after it are acknowledged, but they leave all registers unchanged.
- R7: A start or stop resets the byte position to 0. A byte cut off by a start or stop is not written, and a repeated start loads from byte 0 again.
- R8: After a stop the target releases SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line (as seen on the wire) |
| sda_pull_o | output | 1 | When 1, the pad pulls SDA low (acknowledge) |
| func_o | output | 8 | Byte 0: function/mode selection |
| cpu_en_o | output | 8 | Byte 1: CPU clock enables (3:0), USB enable (7) |
| pci_en_o | output | 8 | Byte 2: PCI enables (5:0), free-running PCI enable (6) |
| sdr_lo_en_o | output | 8 | Byte 3: SDRAM 7..0 enables |
| sdr_hi_en_o | output | 8 | Byte 4: SDRAM 11..8 enables (3:0) |
| per_en_o | output | 8 | Byte 5: reference enable (0), IOAPIC enable (4) |

## Verification
The assertions check four rules on every cycle:

- The acknowledge pull is released one cycle after a stop.
- The acknowledge pull never begins while SCL is high.
- No pull is made while the target is ignoring the bus.
- The registers change only during the data phase, and the byte position is reset by a start and never goes past the end of the bank.

Only the bench scenarios can show what ends up in the registers. These are the masked values, the MSB-first order, the rejection of a wrong address or a read, the dropping of bytes past the end, and the loss of a byte cut off by a repeated start.

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave #(
  parameter logic [6:0] DEV_ADDR = 7'b1101001
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  output logic [7:0] func_o,
  output logic [7:0] cpu_en_o,
  output logic [7:0] pci_en_o,
  output logic [7:0] sdr_lo_en_o,
  output logic [7:0] sdr_hi_en_o,
  output logic [7:0] per_en_o
);
  localparam int NREG = 6;
  localparam int IW   = $clog2(NREG + 1);

  function automatic logic [7:0] keep_mask(input int i);
    case (i)
      0:       keep_mask = 8'h03;
      1:       keep_mask = 8'h8F;
      2:       keep_mask = 8'h7F;
      3:       keep_mask = 8'hFF;
      4:       keep_mask = 8'h0F;
      5:       keep_mask = 8'h11;
      default: keep_mask = 8'h00;
    endcase
  endfunction

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AWAIT, S_AHOLD, S_DATA, S_IGN} st_t;

  logic [1:0]    scl_sy, sda_sy;
  logic          scl_q, sda_q;
  st_t           state;
  logic [2:0]    bitcnt;
  logic [7:0]    sh;
  logic [IW-1:0] idx;
  logic [7:0]    cfg [NREG];

  wire scl_s     = scl_sy[1];
  wire sda_s     = sda_sy[1];
  wire scl_rise  = scl_s & ~scl_q;
  wire scl_fall  = ~scl_s & scl_q;
  wire start_det = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  wire [7:0] rx_byte = {sh[6:0], sda_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      bitcnt     <= '0;
      sh         <= '0;
      idx        <= '0;
      sda_pull_o <= 1'b0;
      for (int i = 0; i < NREG; i++) cfg[i] <= (i == 0) ? 8'h00 : keep_mask(i);
    end else if (start_det) begin
      state      <= S_ADDR;
      bitcnt     <= '0;
      idx        <= '0;
      sda_pull_o <= 1'b0;
    end else if (stop_det) begin
      state      <= S_IDLE;
      idx        <= '0;
      sda_pull_o <= 1'b0;
    end else begin
      case (state)
        S_ADDR: if (scl_rise) begin
          sh     <= rx_byte;
          bitcnt <= bitcnt + 3'd1;
          if (bitcnt == 3'd7)
            state <= (sh[6:0] == DEV_ADDR && !sda_s) ? S_AWAIT : S_IGN;
        end
        S_DATA: if (scl_rise) begin
          sh     <= rx_byte;
          bitcnt <= bitcnt + 3'd1;
          if (bitcnt == 3'd7) begin
            state <= S_AWAIT;
            if (idx < IW'(NREG)) begin
              for (int i = 0; i < NREG; i++)
                if (idx == IW'(i)) cfg[i] <= rx_byte & keep_mask(i);
              idx <= idx + 1'b1;
            end
          end
        end
        S_AWAIT: if (scl_fall) begin
          sda_pull_o <= 1'b1;
          state      <= S_AHOLD;
        end
        S_AHOLD: if (scl_fall) begin
          sda_pull_o <= 1'b0;
          bitcnt     <= '0;
          state      <= S_DATA;
        end
        default: ;
      endcase
    end
  end

  assign func_o      = cfg[0];
  assign cpu_en_o    = cfg[1];
  assign pci_en_o    = cfg[2];
  assign sdr_lo_en_o = cfg[3];
  assign sdr_hi_en_o = cfg[4];
  assign per_en_o    = cfg[5];

  wire [8*NREG-1:0] cfg_flat = {per_en_o, sdr_hi_en_o, sdr_lo_en_o, pci_en_o, cpu_en_o, func_o};

  p_ack_starts_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> !scl_s);
  p_ignore_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IGN) |-> !sda_pull_o);
  p_regs_only_in_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_DATA) |=> $stable(cfg_flat));
  p_idx_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= IW'(NREG));
  p_start_restarts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (idx == '0 && state == S_ADDR));
  p_stop_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_pull_o);
endmodule

// File: tb/test_cfg_i2c_slave.sv
module test_cfg_i2c_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 25;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_pull;
  logic [7:0] func, cpu_en, pci_en, sdr_lo, sdr_hi, per_en;
  wire sda_bus = sda_m & ~sda_pull;
  int errors = 0, checks = 0, cycles = 0;
  logic ack;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_i2c_slave i_cfg_i2c_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_pull_o(sda_pull), .func_o(func), .cpu_en_o(cpu_en),
    .pci_en_o(pci_en), .sdr_lo_en_o(sdr_lo), .sdr_hi_en_o(sdr_hi),
    .per_en_o(per_en));

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_q(); scl_m = 1'b1; wait_q();
    sda_m = 1'b0; wait_q(); scl_m = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q(); scl_m = 1'b1; wait_q(); sda_m = 1'b1; wait_q();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wait_q(); scl_m = 1'b1; wait_q(); wait_q(); scl_m = 1'b0; wait_q();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic got_ack);
    send_bits(b, 8);
    sda_m = 1'b1; wait_q(); scl_m = 1'b1; wait_q();
    got_ack = !sda_bus; wait_q(); scl_m = 1'b0; wait_q();
  endtask

  task automatic t_reset();
    check("R1 func", func, 8'h00);
    check("R1 cpu", cpu_en, 8'h8F);
    check("R1 pci", pci_en, 8'h7F);
    check("R1 sdr_lo", sdr_lo, 8'hFF);
    check("R1 sdr_hi", sdr_hi, 8'h0F);
    check("R1 per", per_en, 8'h11);
  endtask

  task automatic t_full_write();
    logic [7:0] d [6];
    d = '{8'hFF, 8'h00, 8'hAA, 8'h1E, 8'hF3, 8'hFF};
    bus_start();
    send_byte(8'hD2, ack); check("R2 address ack", {7'd0, ack}, 8'd1);
    for (int i = 0; i < 6; i++) begin
      send_byte(d[i], ack); check("R4 data ack", {7'd0, ack}, 8'd1);
    end
    bus_stop();
    check("R2 released after stop R8", {7'd0, sda_bus}, 8'd1);
    check("R5 func masked", func, 8'h03);
    check("R4 cpu", cpu_en, 8'h00);
    check("R5 pci masked", pci_en, 8'h2A);
    check("R4 sdr_lo msb first", sdr_lo, 8'h1E);
    check("R5 sdr_hi masked", sdr_hi, 8'h03);
    check("R5 per masked", per_en, 8'h11);
  endtask

  task automatic t_wrong_addr();
    bus_start();
    send_byte(8'hD4, ack); check("R3 wrong address nack", {7'd0, ack}, 8'd0);
    send_byte(8'h00, ack); check("R3 ignored byte nack", {7'd0, ack}, 8'd0);
    send_byte(8'hFF, ack);
    bus_stop();
    check("R3 func unchanged", func, 8'h03);
    check("R3 cpu unchanged", cpu_en, 8'h00);
  endtask

  task automatic t_read_bit();
    bus_start();
    send_byte(8'hD3, ack); check("R3 read nack", {7'd0, ack}, 8'd0);
    send_byte(8'h00, ack);
    bus_stop();
    check("R3 func unchanged after read", func, 8'h03);
  endtask

  task automatic t_overflow();
    logic [7:0] d [8];
    d = '{8'h01, 8'h8F, 8'h7F, 8'hFF, 8'h0F, 8'h11, 8'h00, 8'h00};
    bus_start();
    send_byte(8'hD2, ack);
    for (int i = 0; i < 8; i++) begin
      send_byte(d[i], ack);
      if (i >= 6) check("R6 extra byte ack", {7'd0, ack}, 8'd1);
    end
    bus_stop();
    check("R6 func", func, 8'h01);
    check("R6 cpu kept", cpu_en, 8'h8F);
    check("R6 per kept", per_en, 8'h11);
  endtask

  task automatic t_abort();
    bus_start();
    send_byte(8'hD2, ack);
    send_byte(8'h02, ack);
    send_bits(8'h00, 4);
    bus_start();
    send_byte(8'hD2, ack); check("R7 repeated start ack", {7'd0, ack}, 8'd1);
    send_byte(8'h00, ack);
    bus_stop();
    check("R7 restart at byte 0", func, 8'h00);
    check("R7 cut byte not written", cpu_en, 8'h8F);
  endtask

  task automatic t_stop_restart();
    bus_start(); send_byte(8'hD2, ack); send_byte(8'h03, ack); bus_stop();
    bus_start(); send_byte(8'hD2, ack); send_byte(8'h01, ack); bus_stop();
    check("R7 stop resets index", func, 8'h01);
    check("R7 cpu untouched", cpu_en, 8'h8F);
    check("R8 sda released", {7'd0, sda_bus}, 8'd1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_full_write();
    t_wrong_addr();
    t_read_bit();
    t_overflow();
    t_abort();
    t_stop_restart();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule